// File: doc/BRIEF.md
# Activity-Gated Output Hold Controller

This block sits beside a piece of combinational or registered logic and decides when that logic may go to sleep. It samples a bundle of watched signals once per cycle of a fast sampling clock. The bundle holds the dedicated inputs, the bidirectional pins (the clock pin among them) and the internal feedback nets. If no watched bit changes for a parameterised number of sampling edges, the block freezes the logic's outputs at their present value and drops its awake indication.

While it sleeps, the block presents the frozen value and ignores the live logic outputs. The first change seen on any watched bit starts a wake-up. Waking takes a fixed number of extra sampling edges, and the frozen value stays on the outputs for that whole time. After the wake-up the outputs follow the live logic again, and the idle interval is counted afresh.

The power-down decision comes only from inactivity on the watched bundle. No command can force it. The analog supply switching itself lies outside this block.

Top module: `idle_hold_ctrl`

## Requirements
- R1: During reset and after it is released, `awake_o` is 1, the idle count starts from zero and `out_o` equals `live_i`. `held_o` is 0 while reset is held.
- R2: A change is a sampling edge at which `watch_i` differs in any bit from its value at the previous edge. The value before the first edge counts as all zeros. Each change restarts the idle count, so the block stays awake while changes come at least once every `IDLE_CYCLES` edges.
- R3: After `IDLE_CYCLES` consecutive edges with no change, `awake_o` falls. The sleep takes effect at the last of those edges.
- R4: While `awake_o` is 0, `out_o` and `held_o` both equal the `live_i` value sampled at the edge that entered sleep. Changes on `live_i` during that time have no effect on either output.
- R5: While asleep, a change starts a wake-up. `awake_o` rises exactly `WAKE_CYCLES` edges after the edge that saw the change, and `out_o` keeps the frozen value until then.
- R6: Once awake again, `out_o` follows `live_i`. The idle count restarts from zero at the edge that ends the wake-up.
- R7: Changes on `watch_i` during a wake-up neither lengthen nor shorten it.
- R8: While awake, `held_o` takes the value of `live_i` at every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| watch_i | input | WATCH_W | Watched bundle: inputs, pins and feedback nets |
| live_i | input | OUT_W | Live outputs of the governed logic |
| out_o | output | OUT_W | Presented outputs, either live or frozen |
| held_o | output | OUT_W | Latched output bus |
| awake_o | output | 1 | 1 while active, 0 during sleep and wake-up |

## Verification
The hardest point to reach is a wake-up that is disturbed by further activity. The bench has to let the bundle go quiet for exactly the idle interval to enter sleep, then change it once to start waking, and then change both the watched bundle and the live outputs during the wake window. A cycle model in the bench tracks quiet edges and the wake countdown. That model is how the stimulus can land just below the idle threshold, exactly on it, and inside the wake window, and it predicts every output for each edge.

// File: rtl/idle_hold_pkg.sv
package idle_hold_pkg;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_DOZE = 2'd1,
    PH_RISE = 2'd2
  } phase_t;

  // Counter has reached the final step of a window of length lim.
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return cnt == (lim - 1);
  endfunction

  // Any bit of two samples differs.
  function automatic logic differs(input logic [63:0] a, input logic [63:0] b);
    return |(a ^ b);
  endfunction

endpackage

// File: rtl/idle_change_det.sv
module idle_change_det #(
  parameter int WATCH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WATCH_W-1:0] sample_i,
  output logic               change_o
);
  import idle_hold_pkg::*;

  localparam int PAD = 64 - WATCH_W;

  logic [WATCH_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sample_i;
  end

  always_comb begin
    change_o = differs({{PAD{1'b0}}, sample_i}, {{PAD{1'b0}}, prev_q});
  end

endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic hit_o
);
  import idle_hold_pkg::*;

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_comb begin
    hit_o = run_i && !clear_i && at_last(32'(cnt_q), LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear_i || hit_o) cnt_q <= '0;
    else if (run_i)            cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/idle_wake_delay.sv
module idle_wake_delay #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  import idle_hold_pkg::*;

  localparam int CW = $clog2(LEN + 1);

  logic          on_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    done_o = on_q && at_last(32'(cnt_q), LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (on_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/idle_hold_ctrl.sv
module idle_hold_ctrl #(
  parameter int WATCH_W     = 6,
  parameter int OUT_W       = 4,
  parameter int IDLE_CYCLES = 8,
  parameter int WAKE_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WATCH_W-1:0] watch_i,
  input  logic [OUT_W-1:0]   live_i,
  output logic [OUT_W-1:0]   out_o,
  output logic [OUT_W-1:0]   held_o,
  output logic               awake_o
);
  import idle_hold_pkg::*;

  phase_t           phase_q, phase_d;
  logic [OUT_W-1:0] held_q;

  // Named internal events, visible to the checker
  logic change_seen;
  logic idle_hit;
  logic wake_done;
  logic sleep_enter;
  logic wake_start;
  logic running;

  idle_change_det #(.WATCH_W(WATCH_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (watch_i),
    .change_o (change_seen)
  );

  idle_timer #(.LIMIT(IDLE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (running),
    .clear_i (change_seen || !running),
    .hit_o   (idle_hit)
  );

  idle_wake_delay #(.LEN(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (wake_start),
    .done_o  (wake_done)
  );

  always_comb begin
    running     = (phase_q == PH_RUN);
    sleep_enter = idle_hit;
    wake_start  = (phase_q == PH_DOZE) && change_seen;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_RUN:  if (sleep_enter) phase_d = PH_DOZE;
      PH_DOZE: if (wake_start)  phase_d = PH_RISE;
      PH_RISE: if (wake_done)   phase_d = PH_RUN;
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RUN;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (running) held_q <= live_i;
  end

  genvar gi;
  generate
    for (gi = 0; gi < OUT_W; gi++) begin : g_sel
      assign out_o[gi] = running ? live_i[gi] : held_q[gi];
    end
  endgenerate

  assign held_o  = held_q;
  assign awake_o = running;

endmodule

// File: rtl/idle_hold_chk.sv
module idle_hold_chk #(
  parameter int OUT_W       = 4,
  parameter int WAKE_CYCLES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             awake_o,
  input logic [OUT_W-1:0] out_o,
  input logic [OUT_W-1:0] held_o,
  input logic [OUT_W-1:0] live_i,
  input logic             change_seen,
  input logic             sleep_enter,
  input logic             wake_start
);

  int unsigned wake_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   wake_age <= 0;
    else if (wake_start)                          wake_age <= 0;
    else if (!awake_o && wake_age <= WAKE_CYCLES) wake_age <= wake_age + 1;
  end

  AST_ACTIVITY_KEEPS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (awake_o && change_seen) |=> awake_o); // R2

  AST_QUIET_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_enter |=> !awake_o); // R3

  AST_FROZEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !awake_o |-> (out_o == held_o)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake_o && $past(!awake_o)) |-> $stable(held_o)); // R4

  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |-> !awake_o); // R5

  AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake_o) |-> (wake_age == WAKE_CYCLES)); // R5

  AST_HELD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    awake_o |=> (held_o == $past(live_i))); // R8

endmodule

bind idle_hold_ctrl idle_hold_chk #(
  .OUT_W       (OUT_W),
  .WAKE_CYCLES (WAKE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .awake_o     (awake_o),
  .out_o       (out_o),
  .held_o      (held_o),
  .live_i      (live_i),
  .change_seen (change_seen),
  .sleep_enter (sleep_enter),
  .wake_start  (wake_start)
);

// File: tb/tb_idle_hold_ctrl.sv
module tb_idle_hold_ctrl;

  localparam int WATCH_W = 6;
  localparam int OUT_W   = 4;
  localparam int IDLE    = 8;
  localparam int WAKE    = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [WATCH_W-1:0] watch = '0;
  logic [OUT_W-1:0]   live = 4'h5;
  logic [OUT_W-1:0]   out_o, held_o;
  logic               awake_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  idle_hold_ctrl #(
    .WATCH_W(WATCH_W), .OUT_W(OUT_W), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .watch_i(watch), .live_i(live),
    .out_o(out_o), .held_o(held_o), .awake_o(awake_o)
  );

  // Scoreboard queues
  bit               q_aw[$];
  logic [OUT_W-1:0] q_out[$];
  logic [OUT_W-1:0] q_held[$];
  string            q_tag[$];

  // Reference model state
  int               m_mode  = 0;   // 0 awake, 1 asleep, 2 waking
  int               m_quiet = 0;
  int               m_wk    = 0;
  logic [WATCH_W-1:0] m_prev = '0;
  logic [OUT_W-1:0]   m_held = '0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [WATCH_W-1:0] w, input logic [OUT_W-1:0] l, input string tag);
    bit moved;
    @(negedge clk);
    watch = w;
    live  = l;
    moved = (w != m_prev);
    m_prev = w;
    if (m_mode == 0) begin
      m_held = l;
      m_quiet = moved ? 0 : m_quiet + 1;
      if (m_quiet == IDLE) m_mode = 1;
    end else if (m_mode == 1) begin
      if (moved) begin
        m_mode = 2;
        m_wk = 0;
      end
    end else begin
      m_wk++;
      if (m_wk == WAKE) begin
        m_mode = 0;
        m_quiet = 0;
      end
    end
    q_aw.push_back(m_mode == 0);
    q_out.push_back((m_mode == 0) ? l : m_held);
    q_held.push_back(m_held);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare after every active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_aw.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check(t, {7'd0, awake_o}, {7'd0, q_aw.pop_front()}, "awake_o");
        check(t, {4'd0, out_o},   {4'd0, q_out.pop_front()}, "out_o");
        check(t, {4'd0, held_o},  {4'd0, q_held.pop_front()}, "held_o");
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {7'd0, awake_o}, 8'd1, "awake_o in reset");
    check("R1", {4'd0, out_o},   8'h05, "out_o in reset");
    check("R1", {4'd0, held_o},  8'h00, "held_o in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: counting starts from zero, stays awake short of the limit
    for (int i = 0; i < IDLE - 2; i++) step('0, 4'h5, "R1");

    // R2: single-bit changes in different positions restart the count
    step(6'h20, 4'h5, "R2");
    for (int i = 0; i < IDLE - 1; i++) step(6'h20, 4'h5, "R2");
    step(6'h21, 4'h5, "R2");
    for (int i = 0; i < IDLE - 1; i++) step(6'h21, 4'h5, "R2");
    step(6'h01, 4'h5, "R2");

    // R8: held bus follows live while awake
    step(6'h01, 4'h1, "R8");
    step(6'h01, 4'h2, "R8");
    step(6'h01, 4'h9, "R8");

    // R3: quiet until sleep (enters on the exact edge)
    for (int i = 0; i < IDLE; i++) step(6'h01, 4'h9, "R3");

    // R4: live changes while asleep have no effect
    step(6'h01, 4'h3, "R4");
    step(6'h01, 4'hE, "R4");
    step(6'h01, 4'h0, "R4");

    // R5: a change wakes with fixed latency, output still frozen
    step(6'h11, 4'hC, "R5");
    // R7: activity inside the wake window does not move its end
    step(6'h13, 4'hC, "R7");
    step(6'h03, 4'hB, "R7");
    step(6'h07, 4'hB, "R7");

    // R6: live outputs again, idle count restarted
    step(6'h07, 4'hA, "R6");
    step(6'h07, 4'h6, "R6");
    for (int i = 0; i < IDLE + 2; i++) step(6'h07, 4'h6, "R6");

    // R5: second wake from a different bit
    step(6'h27, 4'h8, "R5");
    for (int i = 0; i < WAKE + 2; i++) step(6'h27, 4'h8, "R5");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule